// File: doc/BRIEF.md
# Deep-sleep power handshake controller

This block sequences a platform into and out of a deep-sleep power state together with the platform's controller hub. The hub announces entry by pulling the active-low suspend-warning low and then removes the 5 V dual rail. The controller watches a comparator flag that reports the dual rail below its threshold. It acknowledges only once that flag has held steady for a programmable number of cycles. When the hub then asserts the active-low sleep-suspend, the controller switches off the 5 V and 3.3 V standby rails. Exit runs in the reverse order: the standby rails come back when sleep-suspend releases, and the handshake closes when suspend-warning releases.

The controller owns the deep-sleep rails rather than the hub, so it can wake the platform on its own. Six wake sources (RTC, power button, GPIO, LAN, keyboard/mouse, serial ring-indicate) each have an enable bit. An enabled request seen during sleep restores the rails and latches into a sticky status word that clears on a read strobe. An optional idle timeout moves the platform from deep sleep into a deeper off state, where a second active-low output also removes an always-on rail. All hub, comparator and wake inputs are asynchronous and pass through two-flop synchronizers. No data stream crosses this block, so every pin is a plain level or strobe and has no valid/ready handshake.

Top module: `deep_sleep_ctrl`

## Requirements
- R1: After reset, ack_n, stby_off_n and aon_off_n are all 1 and wake_stat is 0.
- R2: The rail-low flag is accepted only after its synchronized value has been 1 on more than rail_hold consecutive clock edges. A pulse of rail_hold cycles or fewer is ignored.
- R3: Once warn_n is low, ack_n falls only after the rail-low flag has been accepted. With rail_low and warn_n changing together, ack_n falls on the 4+rail_hold-th rising edge after the change.
- R4: While acknowledged, slp_n going low drives stby_off_n low on the third rising edge after the change. ack_n stays low.
- R5: In deep sleep, slp_n returning high drives stby_off_n (and aon_off_n) high on the third rising edge after the change. ack_n stays low.
- R6: After exit, warn_n returning high raises ack_n on the third rising edge after the change, and the controller is back in normal run.
- R7: If warn_n returns high before slp_n has fallen, the sequence aborts: ack_n goes high, the rails stay on, and a later rail-low flag alone does not acknowledge.
- R8: Bit order of wake_req, wake_en and wake_stat: 0 RTC, 1 power button, 2 GPIO, 3 LAN, 4 keyboard/mouse, 5 ring-indicate. An enabled request held during deep sleep or deep off turns all rails on by the third rising edge and sets its wake_stat bit. Disabled requests, and any request outside sleep, have no effect on rails or status.
- R9: With deep_off_en set, deep sleep moves to deep off on the idle_limit+1-th rising edge after deep sleep was entered, driving aon_off_n low. With deep_off_en clear, aon_off_n stays high.
- R10: A one-cycle stat_rd clears wake_stat on the next rising edge. A capture in that same cycle is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| warn_n | input | 1 | Suspend-warning from hub, active low, asynchronous |
| slp_n | input | 1 | Sleep-suspend from hub, active low, asynchronous |
| rail_low | input | 1 | Comparator: dual rail under threshold, asynchronous |
| wake_req | input | WAKE_W | Wake requests, bit order per R8, asynchronous |
| wake_en | input | WAKE_W | Per-source wake enable |
| deep_off_en | input | 1 | Allow the idle move into deep off |
| idle_limit | input | IDLE_W | Idle cycles in deep sleep before deep off |
| rail_hold | input | HOLD_W | Stability count for the rail-low flag |
| stat_rd | input | 1 | Read strobe, clears wake_stat |
| wake_stat | output | WAKE_W | Sticky wake-source status |
| ack_n | output | 1 | Suspend-acknowledge to hub, active low |
| stby_off_n | output | 1 | Low switches off the 5 V and 3.3 V standby rails |
| aon_off_n | output | 1 | Low switches off the always-on rail |

## Verification
The state register is visible only through the three handshake outputs. A state that is wrong shows up as ack_n or a rail control out of step with the hub inputs, within three clock edges of the input change that should have moved it. A filter that is broken shows up as an acknowledgement that comes one or more edges early, or comes after a glitch. A faulty idle timer shows up as aon_off_n falling at the wrong edge. A wrong wake path shows up either as rails coming back on a disabled source or as a status bit that is set or cleared at the wrong time. The bench samples every output at a fixed edge count after each stimulus, so an error of a single cycle is caught.

// File: rtl/dsw_pkg.sv
package dsw_pkg;
  typedef enum logic [2:0] {
    ST_RUN      = 3'd0,
    ST_WAIT_LOW = 3'd1,
    ST_ACKED    = 3'd2,
    ST_DSW      = 3'd3,
    ST_DEEP     = 3'd4,
    ST_EXIT     = 3'd5
  } pwr_state_e;

  localparam int unsigned SYNC_STAGES = 2;
endpackage

// File: rtl/dsw_sync.sv
module dsw_sync #(
  parameter int unsigned W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [dsw_pkg::SYNC_STAGES];

  genvar g;
  generate
    for (g = 0; g < dsw_pkg::SYNC_STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage[g] <= RST_VAL;
        else if (g == 0) stage[g] <= d;
        else stage[g] <= stage[(g == 0) ? 0 : g - 1];
      end
    end
  endgenerate

  assign q = stage[dsw_pkg::SYNC_STAGES-1];
endmodule

// File: rtl/dsw_rail_filter.sv
module dsw_rail_filter #(
  parameter int unsigned HOLD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rail_in,
  input  logic [HOLD_W-1:0] hold,
  output logic              rail_ok
);
  logic [HOLD_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      rail_ok <= 1'b0;
    end else if (!rail_in) begin
      cnt_q   <= '0;
      rail_ok <= 1'b0;
    end else if (cnt_q >= hold) begin
      rail_ok <= 1'b1;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R2
  drop_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rail_ok && !rail_in) |=> !rail_ok);
endmodule

// File: rtl/dsw_wake_status.sv
module dsw_wake_status #(
  parameter int unsigned WAKE_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WAKE_W-1:0] wake_s,
  input  logic [WAKE_W-1:0] wake_en,
  input  logic              asleep,
  input  logic              stat_rd,
  output logic              wake_hit,
  output logic [WAKE_W-1:0] stat_q
);
  logic [WAKE_W-1:0] cap;

  assign cap      = wake_s & wake_en & {WAKE_W{asleep}};
  assign wake_hit = |cap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= (stat_rd ? '0 : stat_q) | cap;
  end

  // R10
  read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !wake_hit) |=> (stat_q == '0));
  // R8
  awake_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!asleep && !stat_rd) |=> $stable(stat_q));
endmodule

// File: rtl/dsw_fsm.sv
module dsw_fsm #(
  parameter int unsigned IDLE_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              warn_s,
  input  logic              slp_s,
  input  logic              rail_ok,
  input  logic              wake_hit,
  input  logic              deep_en,
  input  logic [IDLE_W-1:0] idle_limit,
  output logic              ack_n,
  output logic              stby_off_n,
  output logic              aon_off_n,
  output logic              asleep
);
  import dsw_pkg::*;

  pwr_state_e        state_q, state_d;
  logic [IDLE_W-1:0] idle_q;
  logic              idle_done;

  assign idle_done = (state_q == ST_DSW) && (idle_q == idle_limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  idle_q <= '0;
    else if (state_q != ST_DSW)  idle_q <= '0;
    else if (!idle_done)         idle_q <= idle_q + 1'b1;
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RUN:      if (!warn_s) state_d = ST_WAIT_LOW;
      ST_WAIT_LOW: if (warn_s) state_d = ST_RUN;
                   else if (rail_ok) state_d = ST_ACKED;
      ST_ACKED:    if (warn_s) state_d = ST_RUN;
                   else if (!slp_s) state_d = ST_DSW;
      ST_DSW:      if (slp_s || wake_hit) state_d = ST_EXIT;
                   else if (deep_en && idle_done) state_d = ST_DEEP;
      ST_DEEP:     if (slp_s || wake_hit) state_d = ST_EXIT;
      ST_EXIT:     if (warn_s) state_d = ST_RUN;
      default:     state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_RUN;
      ack_n      <= 1'b1;
      stby_off_n <= 1'b1;
      aon_off_n  <= 1'b1;
      asleep     <= 1'b0;
    end else begin
      state_q    <= state_d;
      ack_n      <= !(state_d inside {ST_ACKED, ST_DSW, ST_DEEP, ST_EXIT});
      stby_off_n <= !(state_d inside {ST_DSW, ST_DEEP});
      aon_off_n  <= (state_d != ST_DEEP);
      asleep     <= (state_d inside {ST_DSW, ST_DEEP});
    end
  end

  // R4
  rails_need_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !stby_off_n |-> !ack_n);
  // R9
  aon_under_stby_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !aon_off_n |-> !stby_off_n);
  // R3
  ack_after_rail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ack_n) |-> $past(rail_ok));
  // R7
  abort_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ACKED && warn_s) |=> (ack_n && stby_off_n));
  // R8
  wake_restores_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (asleep && wake_hit) |=> (stby_off_n && aon_off_n));
endmodule

// File: rtl/deep_sleep_ctrl.sv
module deep_sleep_ctrl #(
  parameter int unsigned WAKE_W = 6,
  parameter int unsigned HOLD_W = 8,
  parameter int unsigned IDLE_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              warn_n,
  input  logic              slp_n,
  input  logic              rail_low,
  input  logic [WAKE_W-1:0] wake_req,
  input  logic [WAKE_W-1:0] wake_en,
  input  logic              deep_off_en,
  input  logic [IDLE_W-1:0] idle_limit,
  input  logic [HOLD_W-1:0] rail_hold,
  input  logic              stat_rd,
  output logic [WAKE_W-1:0] wake_stat,
  output logic              ack_n,
  output logic              stby_off_n,
  output logic              aon_off_n
);
  localparam int unsigned CTRL_W = 3;

  logic [CTRL_W-1:0] ctrl_s;
  logic [WAKE_W-1:0] wake_s;
  logic              rail_ok, wake_hit, asleep;

  dsw_sync #(.W(CTRL_W), .RST_VAL(3'b011)) u_ctrl_sync (
    .clk(clk), .rst_n(rst_n), .d({rail_low, slp_n, warn_n}), .q(ctrl_s));

  dsw_sync #(.W(WAKE_W), .RST_VAL('0)) u_wake_sync (
    .clk(clk), .rst_n(rst_n), .d(wake_req), .q(wake_s));

  dsw_rail_filter #(.HOLD_W(HOLD_W)) u_filter (
    .clk(clk), .rst_n(rst_n), .rail_in(ctrl_s[2]), .hold(rail_hold),
    .rail_ok(rail_ok));

  dsw_wake_status #(.WAKE_W(WAKE_W)) u_status (
    .clk(clk), .rst_n(rst_n), .wake_s(wake_s), .wake_en(wake_en),
    .asleep(asleep), .stat_rd(stat_rd), .wake_hit(wake_hit),
    .stat_q(wake_stat));

  dsw_fsm #(.IDLE_W(IDLE_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .warn_s(ctrl_s[0]), .slp_s(ctrl_s[1]),
    .rail_ok(rail_ok), .wake_hit(wake_hit), .deep_en(deep_off_en),
    .idle_limit(idle_limit), .ack_n(ack_n), .stby_off_n(stby_off_n),
    .aon_off_n(aon_off_n), .asleep(asleep));
endmodule

// File: tb/sim_deep_sleep_ctrl.sv
module sim_deep_sleep_ctrl;
  localparam int W = 6;

  typedef struct {
    bit         use_rails;
    logic [2:0] rails;
    bit         use_stat;
    logic [W-1:0] stat;
    string      tag;
  } exp_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic warn_n = 1'b1, slp_n = 1'b1, rail_low = 1'b0, deep_off_en = 1'b0, stat_rd = 1'b0;
  logic [W-1:0] wake_req = '0, wake_en = 6'b111110;
  logic [15:0] idle_limit = 16'd5;
  logic [7:0]  rail_hold = 8'd3;
  logic [W-1:0] wake_stat;
  logic ack_n, stby_off_n, aon_off_n;

  int checks = 0, failures = 0;
  bit done = 0;
  exp_t sb[$];

  always #10 clk = ~clk;

  deep_sleep_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .warn_n(warn_n), .slp_n(slp_n), .rail_low(rail_low),
    .wake_req(wake_req), .wake_en(wake_en), .deep_off_en(deep_off_en),
    .idle_limit(idle_limit), .rail_hold(rail_hold), .stat_rd(stat_rd),
    .wake_stat(wake_stat), .ack_n(ack_n), .stby_off_n(stby_off_n), .aon_off_n(aon_off_n));

  task automatic ticks(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic exp_rails(input logic a, input logic s, input logic o, input string tag);
    exp_t e;
    e.use_rails = 1; e.rails = {a, s, o}; e.use_stat = 0; e.stat = '0; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic exp_stat(input logic [W-1:0] v, input string tag);
    exp_t e;
    e.use_rails = 0; e.rails = '0; e.use_stat = 1; e.stat = v; e.tag = tag;
    sb.push_back(e);
  endtask

  // monitor: compares queued expectations at the falling edge
  initial forever begin
    @(negedge clk);
    while (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      checks++;
      if (e.use_rails && ({ack_n, stby_off_n, aon_off_n} !== e.rails)) begin
        failures++;
        $display("FAIL %s: {ack_n,stby_off_n,aon_off_n}=%b expected %b", e.tag,
                 {ack_n, stby_off_n, aon_off_n}, e.rails);
      end
      if (e.use_stat && (wake_stat !== e.stat)) begin
        failures++;
        $display("FAIL %s: wake_stat=%b expected %b", e.tag, wake_stat, e.stat);
      end
    end
  end

  task automatic enter_dsw();
    @(negedge clk); warn_n = 1'b0; rail_low = 1'b1;
    ticks(7);
    @(negedge clk); slp_n = 1'b0;
    ticks(3);
  endtask

  task automatic leave();
    @(negedge clk); slp_n = 1'b1;
    ticks(3);
    @(negedge clk); warn_n = 1'b1; rail_low = 1'b0;
    ticks(3);
  endtask

  initial begin
    ticks(2);
    @(negedge clk); rst_n = 1'b1;
    ticks(1);
    exp_rails(1, 1, 1, "R1 reset rails");
    exp_stat('0, "R1 reset status");

    // R8: wake while running is ignored
    @(negedge clk); wake_req = '1;
    ticks(4);
    @(negedge clk); wake_req = '0;
    ticks(4);
    exp_stat('0, "R8 wake in run ignored");
    exp_rails(1, 1, 1, "R8 rails in run");

    // R3/R4/R5/R6 full handshake
    @(negedge clk); warn_n = 1'b0; rail_low = 1'b1;
    ticks(5);
    exp_rails(1, 1, 1, "R3 no ack before filter");
    ticks(2);
    exp_rails(0, 1, 1, "R3 ack after filter");
    @(negedge clk); slp_n = 1'b0;
    ticks(3);
    exp_rails(0, 0, 1, "R4 standby off");
    // R8: disabled source (bit 0) in sleep
    @(negedge clk); wake_req = 6'b000001;
    ticks(3);
    @(negedge clk); wake_req = '0;
    ticks(3);
    exp_rails(0, 0, 1, "R8 disabled wake ignored");
    exp_stat('0, "R8 disabled wake no status");
    @(negedge clk); slp_n = 1'b1;
    ticks(3);
    exp_rails(0, 1, 1, "R5 exit rails on");
    @(negedge clk); warn_n = 1'b1; rail_low = 1'b0;
    ticks(3);
    exp_rails(1, 1, 1, "R6 back to run");

    // R7 abort after acknowledge
    @(negedge clk); warn_n = 1'b0; rail_low = 1'b1;
    ticks(7);
    exp_rails(0, 1, 1, "R7 acked before abort");
    @(negedge clk); warn_n = 1'b1;
    ticks(3);
    exp_rails(1, 1, 1, "R7 abort releases ack");
    @(negedge clk); rail_low = 1'b0;
    // R7 abort before rail drop; later rail flag alone must not ack
    @(negedge clk); warn_n = 1'b0;
    ticks(4);
    @(negedge clk); warn_n = 1'b1;
    ticks(3);
    @(negedge clk); rail_low = 1'b1;
    ticks(10);
    exp_rails(1, 1, 1, "R7 rail alone no ack");
    @(negedge clk); rail_low = 1'b0;
    ticks(3);

    // R2 glitch filter
    @(negedge clk); warn_n = 1'b0;
    ticks(4);
    @(negedge clk); rail_low = 1'b1;
    repeat (3) @(negedge clk);
    rail_low = 1'b0;
    ticks(10);
    exp_rails(1, 1, 1, "R2 short pulse ignored");
    @(negedge clk); rail_low = 1'b1;
    ticks(5);
    exp_rails(1, 1, 1, "R2 not yet stable");
    ticks(2);
    exp_rails(0, 1, 1, "R2 stable pulse accepted");
    @(negedge clk); warn_n = 1'b1; rail_low = 1'b0;
    ticks(3);
    exp_rails(1, 1, 1, "R7 abort after R2 test");

    // R8/R10 wake from deep sleep, read-clear
    enter_dsw();
    exp_rails(0, 0, 1, "R4 in sleep");
    @(negedge clk); wake_req = 6'b000100;
    ticks(3);
    exp_rails(0, 1, 1, "R8 enabled wake restores rails");
    exp_stat(6'b000100, "R8 wake status bit");
    @(negedge clk); wake_req = '0;
    ticks(4);
    exp_stat(6'b000100, "R10 status sticky");
    @(negedge clk); stat_rd = 1'b1;
    ticks(1);
    exp_stat('0, "R10 read clears");
    @(negedge clk); stat_rd = 1'b0;
    leave();
    exp_rails(1, 1, 1, "R6 run after wake");

    // R9 deep off after idle timeout, then wake from it
    deep_off_en = 1'b1;
    enter_dsw();
    ticks(4);
    exp_rails(0, 0, 1, "R9 before timeout");
    ticks(2);
    exp_rails(0, 0, 0, "R9 deep off");
    @(negedge clk); wake_req = 6'b100000;
    ticks(3);
    exp_rails(0, 1, 1, "R8 wake from deep off");
    exp_stat(6'b100000, "R8 ring status");
    @(negedge clk); wake_req = '0; stat_rd = 1'b1;
    ticks(1);
    exp_stat('0, "R10 read clears again");
    @(negedge clk); stat_rd = 1'b0;
    leave();

    // R9 disabled: stays in deep sleep
    deep_off_en = 1'b0;
    enter_dsw();
    ticks(30);
    exp_rails(0, 0, 1, "R9 no deep off when disabled");
    leave();
    exp_rails(1, 1, 1, "R6 final run");

    @(negedge clk);
    @(negedge clk);
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    ticks(20000);
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule